// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit RISC-V style core fetches from next. It takes the fetched instruction word and the two source register values, and it holds the current program counter in a register. Each cycle it produces, without any clock delay, the address that follows the current instruction, a flag that marks a change in control flow, and the return address to be written back for the two jump forms.

It rebuilds the conditional-branch and direct-jump offsets from the scattered immediate bits of the instruction word. Both offsets have an implicit zero least significant bit, so they count in 2-byte steps. It evaluates the six compare conditions, signed and unsigned, and forms the register-indirect jump target with bit 0 forced low. The stored PC takes the computed next address on any cycle where the advance input is high and holds its value otherwise. The advance input is a plain control pin. The instruction and operands are sampled as levels, so the block imposes no back-pressure: a caller that stalls simply keeps the advance input low and the PC stays put.

Top module: `npc_unit`

## Requirements
- R1: After reset the stored PC (`pc_q`) reads 0x00000000.
- R2: For any opcode other than 1100011 (branch), 1101111 (direct jump) or 1100111 (indirect jump), `next_pc` is `pc_q`+4, and both `taken` and `link_we` are 0.
- R3: The branch offset is the sign-extended value whose bit 12 is instr[31], bit 11 is instr[7], bits 10:5 are instr[30:25], bits 4:1 are instr[11:8] and bit 0 is zero. A branch whose condition holds gives `next_pc` = `pc_q` + offset and `taken` = 1. A branch whose condition fails gives `pc_q`+4 and `taken` = 0.
- R4: funct3 (instr[14:12]) 000 branches when the operands are equal, and 001 branches when they differ.
- R5: funct3 100 branches when rs1 < rs2 as two's-complement values, and 101 branches when rs1 >= rs2 as two's-complement values.
- R6: funct3 110 branches when rs1 < rs2 as unsigned values, and 111 branches when rs1 >= rs2 as unsigned values.
- R7: A branch opcode with funct3 010 or 011 never branches. It gives `pc_q`+4 with `taken` = 0.
- R8: The direct jump gives `next_pc` = `pc_q` + offset with `taken` = 1. Its offset is sign-extended, with bit 20 from instr[31], bits 19:12 from instr[19:12], bit 11 from instr[20], bits 10:1 from instr[30:21] and bit 0 zero.
- R9: The indirect jump gives `next_pc` = (rs1 + sign-extended instr[31:20]) with bit 0 cleared, and `taken` = 1.
- R10: `link_we` is 1 exactly for the two jump opcodes, and in that case `link_val` equals `pc_q`+4. Branches never assert `link_we`.
- R11: On a rising clock edge with `step` high, `pc_q` takes the value `next_pc` had before the edge. With `step` low, `pc_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Advance the stored PC to `next_pc` at this edge |
| instr | input | 32 | Instruction word at the current PC |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| pc_q | output | 32 | Current stored program counter |
| next_pc | output | 32 | Address of the following instruction |
| taken | output | 1 | Control flow leaves the sequential path |
| link_val | output | 32 | Return address for the jump forms |
| link_we | output | 1 | Write enable for `link_val` into rd |

## Verification
Equal and unequal operand pairs separate the equality conditions from the ordering conditions. Pairs where one operand is negative and the other positive give opposite answers under signed and unsigned compare, which exposes a swapped or wrongly signed comparator. Offsets at both extremes of their range, and negative ones, exercise every scattered immediate bit and the sign extension. The indirect jump is fed odd sums to show the cleared bit 0. Random streams mix all opcodes with advance pulses that are held low at random, and are compared against a behavioural model every cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 7;
  localparam int unsigned F3_W    = 3;

  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
  localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_BR   = 2'd1,
    FLOW_JAL  = 2'd2,
    FLOW_JALR = 2'd3
  } flow_kind_e;

  typedef enum logic [F3_W-1:0] {
    CMP_EQ  = 3'b000,
    CMP_NE  = 3'b001,
    CMP_LT  = 3'b100,
    CMP_GE  = 3'b101,
    CMP_LTU = 3'b110,
    CMP_GEU = 3'b111
  } cmp_code_e;

  function automatic flow_kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_BRANCH: classify = FLOW_BR;
      OPC_JAL:    classify = FLOW_JAL;
      OPC_JALR:   classify = FLOW_JALR;
      default:    classify = FLOW_SEQ;
    endcase
  endfunction
endpackage

// File: rtl/npc_imm_unpack.sv
module npc_imm_unpack #(
  parameter int unsigned XLEN = 32
) (
  input  logic [31:7]     instr_hi,
  output logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] jal_off,
  output logic [XLEN-1:0] jr_off
);
  localparam int unsigned BR_W  = 13;
  localparam int unsigned JAL_W = 21;
  localparam int unsigned JR_W  = 12;

  logic [BR_W-1:0]  br_raw;
  logic [JAL_W-1:0] jal_raw;
  logic [JR_W-1:0]  jr_raw;

  always_comb begin
    br_raw  = {instr_hi[31], instr_hi[7], instr_hi[30:25], instr_hi[11:8], 1'b0};
    jal_raw = {instr_hi[31], instr_hi[19:12], instr_hi[20], instr_hi[30:21], 1'b0};
    jr_raw  = instr_hi[31:20];
  end

  assign br_off  = {{(XLEN-BR_W){br_raw[BR_W-1]}}, br_raw};
  assign jal_off = {{(XLEN-JAL_W){jal_raw[JAL_W-1]}}, jal_raw};
  assign jr_off  = {{(XLEN-JR_W){jr_raw[JR_W-1]}}, jr_raw};
endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  input  logic [F3_W-1:0] code,
  output logic            hit
);
  logic same, below_s, below_u;

  always_comb begin
    same    = (lhs == rhs);
    below_s = ($signed(lhs) < $signed(rhs));
    below_u = (lhs < rhs);
  end

  always_comb begin
    case (code)
      CMP_EQ:  hit = same;
      CMP_NE:  hit = !same;
      CMP_LT:  hit = below_s;
      CMP_GE:  hit = !below_s;
      CMP_LTU: hit = below_u;
      CMP_GEU: hit = !below_u;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target_mux.sv
module npc_target_mux
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_kind_e      kind,
  input  logic            cond_hit,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] base_reg,
  input  logic [XLEN-1:0] br_off,
  input  logic [XLEN-1:0] jal_off,
  input  logic [XLEN-1:0] jr_off,
  output logic [XLEN-1:0] tgt,
  output logic            redirect,
  output logic [XLEN-1:0] ret_addr,
  output logic            ret_we
);
  localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] ALIGN_MASK  = ~XLEN'(1);

  logic [XLEN-1:0] seq_pc, br_pc, jal_pc, jr_sum;

  always_comb begin
    seq_pc = cur_pc + INSTR_BYTES;
    br_pc  = cur_pc + br_off;
    jal_pc = cur_pc + jal_off;
    jr_sum = base_reg + jr_off;
  end

  always_comb begin
    tgt      = seq_pc;
    redirect = 1'b0;
    ret_we   = 1'b0;
    case (kind)
      FLOW_BR: begin
        if (cond_hit) begin
          tgt      = br_pc;
          redirect = 1'b1;
        end
      end
      FLOW_JAL: begin
        tgt      = jal_pc;
        redirect = 1'b1;
        ret_we   = 1'b1;
      end
      FLOW_JALR: begin
        tgt      = jr_sum & ALIGN_MASK;
        redirect = 1'b1;
        ret_we   = 1'b1;
      end
      default: ;
    endcase
  end

  assign ret_addr = seq_pc;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] next_pc,
  output logic            taken,
  output logic [XLEN-1:0] link_val,
  output logic            link_we
);
  flow_kind_e      kind;
  logic            cond_hit;
  logic [XLEN-1:0] br_off, jal_off, jr_off;
  logic [XLEN-1:0] pc_r;

  assign kind = classify(instr[OPC_W-1:0]);

  npc_imm_unpack #(.XLEN(XLEN)) u_imm (
    .instr_hi (instr[31:7]),
    .br_off   (br_off),
    .jal_off  (jal_off),
    .jr_off   (jr_off)
  );

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .lhs  (rs1_val),
    .rhs  (rs2_val),
    .code (instr[14:12]),
    .hit  (cond_hit)
  );

  npc_target_mux #(.XLEN(XLEN)) u_tgt (
    .kind     (kind),
    .cond_hit (cond_hit),
    .cur_pc   (pc_r),
    .base_reg (rs1_val),
    .br_off   (br_off),
    .jal_off  (jal_off),
    .jr_off   (jr_off),
    .tgt      (next_pc),
    .redirect (taken),
    .ret_addr (link_val),
    .ret_we   (link_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc_r <= RESET_PC;
    else if (step) pc_r <= next_pc;
  end

  assign pc_q = pc_r;

  // R11
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pc_q == $past(next_pc));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q));

  // R2
  seq_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[6:0] != OPC_BRANCH && instr[6:0] != OPC_JAL && instr[6:0] != OPC_JALR)
      |-> (next_pc == pc_q + XLEN'(4) && !taken && !link_we));

  // R7
  rsvd_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[6:0] == OPC_BRANCH && instr[14:13] == 2'b01) |-> !taken);

  // R10
  link_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_val == pc_q + XLEN'(4));

  // R10
  branch_nolink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[6:0] == OPC_BRANCH |-> !link_we);

  // R9
  jr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr[6:0] == OPC_JALR |-> (next_pc[0] == 1'b0 && taken));
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [31:0] instr = 32'h0000_0013;
  logic [31:0] rs1_val = '0, rs2_val = '0;
  logic [31:0] pc_q, next_pc, link_val;
  logic        taken, link_we;

  int checks = 0;
  int failures = 0;
  logic [31:0] mpc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .step(step), .instr(instr),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .pc_q(pc_q), .next_pc(next_pc),
    .taken(taken), .link_val(link_val), .link_we(link_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_br(input int off, input logic [2:0] f3);
    logic [12:0] o = 13'(off);
    return {o[12], o[10:5], 5'd2, 5'd1, f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_jal(input int off);
    logic [20:0] o = 21'(off);
    return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
  endfunction
  function automatic logic [31:0] enc_jr(input int off);
    logic [11:0] o = 12'(off);
    return {o, 5'd3, 3'b000, 5'd1, 7'b1100111};
  endfunction

  // kind: 0 other, 1 branch, 2 direct jump, 3 indirect jump
  task automatic apply(input int kind, input logic [2:0] f3, input int off,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic stp, input string tag);
    logic [31:0] e_next;
    logic        e_taken, e_we, cnd;
    @(negedge clk);
    rs1_val = a; rs2_val = b; step = stp;
    case (kind)
      1: instr = enc_br(off, f3);
      2: instr = enc_jal(off);
      3: instr = enc_jr(off);
      default: instr = {17'h0, f3, 5'd4, 7'b0110011};
    endcase
    e_next = mpc + 4; e_taken = 0; e_we = 0;
    case (kind)
      1: begin
        case (f3)
          3'b000: cnd = (a == b);
          3'b001: cnd = (a != b);
          3'b100: cnd = ($signed(a) < $signed(b));
          3'b101: cnd = ($signed(a) >= $signed(b));
          3'b110: cnd = (a < b);
          3'b111: cnd = (a >= b);
          default: cnd = 0;
        endcase
        if (cnd) begin e_next = mpc + 32'(off); e_taken = 1; end
      end
      2: begin e_next = mpc + 32'(off); e_taken = 1; e_we = 1; end
      3: begin e_next = (a + 32'(off)) & 32'hFFFF_FFFE; e_taken = 1; e_we = 1; end
      default: ;
    endcase
    #1;
    chk({tag, " R11 pc"}, pc_q, mpc);
    chk({tag, " next_pc"}, next_pc, e_next);
    chk({tag, " taken"}, {31'b0, taken}, {31'b0, e_taken});
    chk({tag, " R10 link_we"}, {31'b0, link_we}, {31'b0, e_we});
    if (e_we) chk({tag, " R10 link_val"}, link_val, mpc + 4);
    @(posedge clk);
    if (stp) mpc = e_next;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk("R1 reset pc", pc_q, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc_q, 32'h0);

    apply(0, 3'b000, 0, 32'h5, 32'h5, 1, "R2 seq");
    apply(0, 3'b010, 0, 32'h1, 32'h2, 0, "R2 hold R11");
    apply(1, 3'b000, 64, 32'h77, 32'h77, 1, "R4 R3 beq hit");
    apply(1, 3'b000, 64, 32'h77, 32'h78, 1, "R4 beq miss");
    apply(1, 3'b001, -8, 32'h1, 32'h2, 1, "R4 bne neg");
    apply(1, 3'b100, 2, 32'hFFFF_FFFF, 32'h1, 1, "R5 blt");
    apply(1, 3'b101, 2, 32'hFFFF_FFFF, 32'h1, 1, "R5 bge");
    apply(1, 3'b110, 2, 32'hFFFF_FFFF, 32'h1, 1, "R6 bltu");
    apply(1, 3'b111, 2, 32'hFFFF_FFFF, 32'h1, 1, "R6 bgeu");
    apply(1, 3'b010, 16, 32'h1, 32'h1, 1, "R7 f3=010");
    apply(1, 3'b011, 16, 32'h0, 32'h9, 1, "R7 f3=011");
    apply(1, 3'b000, -4096, 32'h0, 32'h0, 1, "R3 min off");
    apply(1, 3'b000, 4094, 32'h0, 32'h0, 1, "R3 max off");
    apply(2, 3'b000, -1048576, 32'h0, 32'h0, 1, "R8 jal min");
    apply(2, 3'b000, 1048574, 32'h0, 32'h0, 1, "R8 jal max");
    apply(2, 3'b000, 32'h5556A, 32'h0, 32'h0, 1, "R8 jal mix");
    apply(3, 3'b000, 5, 32'h1000, 32'h0, 1, "R9 jalr odd");
    apply(3, 3'b000, -2048, 32'h0000_0801, 32'h0, 1, "R9 jalr neg");

    for (int i = 0; i < 2000; i++) begin
      int k = int'($urandom_range(0, 3));
      logic [2:0] f = 3'($urandom);
      int off;
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      case (k)
        1: off = $signed(13'($urandom) & 13'h1FFE);
        2: off = $signed(21'($urandom) & 21'h1FFFFE);
        3: off = $signed(12'($urandom));
        default: off = 0;
      endcase
      apply(k, f, off, a, b, 1'($urandom_range(0, 3) != 0), "R3 R8 R9 rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule